// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotational speed of fans by timing the interval between successive rising edges of each fan's tachometer signal. A shared divider turns a slow base-oscillator enable into a counting tick. The selectable ratios are 2, 4, 8 and 16, which give 25, 12.5, 6.25 or 3.125 kHz from a 50 kHz base. Each channel counts ticks between rising edges. At each edge it latches the completed count into an 8-bit result. A small larger count means a slower fan.

A stalled rotor sends no further edges. For this case the channel does not wait. On the tick that would take the counter past 255, the result is forced to 255 and the counter saturates. When the per-channel fault enable is set, a sticky fault also rises. A shared clear drops the faults, but a channel that is still in overflow raises its fault again at once.

Each channel is a two-state machine. ST_RUN counts ticks. On an edge it latches the count and restarts from 0. It moves to ST_STALL on the overflow tick. ST_STALL holds the counter and the result at 255 and returns to ST_RUN on the next rising edge, with the count restarted. Two channels are instantiated by default.

Top module: `fan_tach_monitor`

## Requirements
- R1: The tick fires once every N base enables, with N chosen by `div_sel`: 2'b11 gives 2, 2'b10 gives 4, 2'b01 gives 8 and 2'b00 gives 16.
- R2: Each tach input passes through two synchronising flops before edge detection, and only low-to-high transitions end a period; falling edges have no effect on the result.
- R3: In ST_RUN a detected rising edge loads the tick count since the previous edge (0 to 255) into that channel's result field and restarts the count from 0. An edge wins over a tick that lands in the same cycle.
- R4: On the 256th tick without an edge, the result becomes 255 in the following cycle and the channel enters ST_STALL. There the count does not wrap and the result stays 255. The edge that ends a stall leaves the result at 255 and starts a fresh count.
- R5: After reset every result field reads 255 and every fault bit reads 0.
- R6: When a channel's `fault_en` bit is 1, its overflow tick sets its fault bit in the next cycle.
- R7: A fault bit stays set until `fault_clr` is high. A clear cycle leaves a channel's fault set when that channel's enable is 1 and the channel stays in overflow after that cycle.
- R8: With `fault_en` low a channel never raises its fault bit, even while overflowed.
- R9: The channels run independently. Result field k is `result_o[8k+7:8k]`. They share only the divider and the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_en | input | 1 | One-cycle enable per base-oscillator period |
| div_sel | input | 2 | Tick divide select (R1 encoding) |
| tach_in | input | NCH | Raw asynchronous tach inputs, one per fan |
| fault_en | input | NCH | Per-channel overflow fault enable |
| fault_clr | input | 1 | One-cycle clear of all fault bits |
| result_o | output | NCH*8 | Latched period counts, channel k at bits 8k+7:8k |
| fault_o | output | NCH | Sticky overflow fault per channel |

## Verification
The assertions take for granted that the divide ratio is at least two, so that two ticks are never adjacent. They also assume that a synchronised tach level lasts at least two clock cycles, so that no rising edge is detected two cycles in a row. The bench keeps to both conditions. It drives `base_en` on alternate cycles, which keeps the ticks well apart. It holds every tach level for tens of cycles and changes every input on the falling clock edge. The stall checks hold the tach line still long enough for 256 ticks to pass.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } tach_st_e;
endpackage

// File: rtl/tach_tick_div.sv
module tach_tick_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int DIV_W   = (1 << SEL_W) + 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] ratio;

    assign ratio = DIV_W'(2) << (SEL_W'(MAX_SEL) - div_sel);
    assign tick  = base_en && (div_cnt >= ratio - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (base_en)
            div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
    end

    // R1: ratio of two or more keeps ticks apart
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tach_edge_sync.sv
module tach_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tach_raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 && !s3;

    // R2: a single edge yields a single pulse
    a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tach_period_fsm.sv
module tach_period_fsm
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    input  logic             fault_en,
    input  logic             fault_clr,
    output logic [CNT_W-1:0] result_o,
    output logic             fault_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    tach_st_e         st, st_nxt;
    logic [CNT_W-1:0] cnt;
    logic             ovf_evt;

    assign ovf_evt = (st == ST_RUN) && tick && !rise && (cnt == CNT_MAX);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RUN:   if (ovf_evt) st_nxt = ST_STALL;
            ST_STALL: if (rise)    st_nxt = ST_RUN;
            default:               st_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            result_o <= CNT_MAX;
            fault_o  <= 1'b0;
        end else begin
            unique case (st)
                ST_RUN: begin
                    if (rise) begin
                        result_o <= cnt;
                        cnt      <= '0;
                    end else if (tick) begin
                        if (cnt == CNT_MAX) result_o <= CNT_MAX;
                        else                cnt      <= cnt + CNT_W'(1);
                    end
                end
                ST_STALL: begin
                    if (rise) cnt <= '0;
                end
                default: cnt <= '0;
            endcase
            if (fault_clr)
                fault_o <= fault_en && (st_nxt == ST_STALL);
            else
                fault_o <= fault_o || (fault_en && ovf_evt);
        end
    end

    // R3: edge latches the running count
    a_r3_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && rise) |=> (result_o == $past(cnt)));
    // R4: stalled channel reads full scale and does not wrap
    a_r4_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STALL) |-> (result_o == CNT_MAX && cnt == CNT_MAX));
    // R7: fault is sticky without a clear
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !fault_clr) |=> fault_o);
    // R7: clear during a continuing stall re-raises
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && fault_en && st == ST_STALL && !rise) |=> fault_o);
    // R8: disabled channel never raises a fault
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_en |=> !$rose(fault_o));
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
    parameter int NCH   = 2,
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_en,
    input  logic [SEL_W-1:0]     div_sel,
    input  logic [NCH-1:0]       tach_in,
    input  logic [NCH-1:0]       fault_en,
    input  logic                 fault_clr,
    output logic [NCH*CNT_W-1:0] result_o,
    output logic [NCH-1:0]       fault_o
);
    logic tick;

    tach_tick_div #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_en (base_en),
        .div_sel (div_sel),
        .tick    (tick)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic rise;

        tach_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .tach_raw (tach_in[k]),
            .rise     (rise)
        );

        tach_period_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .rise      (rise),
            .fault_en  (fault_en[k]),
            .fault_clr (fault_clr),
            .result_o  (result_o[k*CNT_W +: CNT_W]),
            .fault_o   (fault_o[k])
        );
    end
endmodule

// File: tb/sim_fan_tach_monitor.sv
module sim_fan_tach_monitor;
    localparam int NCH = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             base_en = 1'b0;
    logic [1:0]       div_sel = 2'b11;
    logic [NCH-1:0]   tach_in = '0;
    logic [NCH-1:0]   fault_en = '0;
    logic             fault_clr = 1'b0;
    logic [NCH*8-1:0] result_o;
    logic [NCH-1:0]   fault_o;

    int vectors = 0;
    int fails   = 0;
    int period [NCH];
    bit running = 1'b0;

    // reference model state
    int m_bcnt;
    int m_q1 [NCH], m_q2 [NCH], m_q3 [NCH];
    int m_el [NCH], m_res [NCH];
    bit m_flt [NCH];

    always #5 clk = ~clk;

    fan_tach_monitor u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_en   (base_en),
        .div_sel   (div_sel),
        .tach_in   (tach_in),
        .fault_en  (fault_en),
        .fault_clr (fault_clr),
        .result_o  (result_o),
        .fault_o   (fault_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bcnt = 0;
            for (int c = 0; c < NCH; c++) begin
                m_q1[c] = 0; m_q2[c] = 0; m_q3[c] = 0;
                m_el[c] = 0; m_res[c] = 255; m_flt[c] = 1'b0;
            end
        end else begin
            int  ratio;
            bit  tk;
            ratio = 2 << (3 - int'(div_sel));
            tk = base_en && (m_bcnt + 1 >= ratio);
            if (base_en) m_bcnt = tk ? 0 : m_bcnt + 1;
            for (int c = 0; c < NCH; c++) begin
                bit rs, ov;
                rs = (m_q2[c] == 1) && (m_q3[c] == 0);
                m_q3[c] = m_q2[c]; m_q2[c] = m_q1[c]; m_q1[c] = int'(tach_in[c]);
                ov = 1'b0;
                if (rs) begin
                    if (m_el[c] <= 255) m_res[c] = m_el[c];
                    m_el[c] = 0;
                end else if (tk && m_el[c] <= 255) begin
                    m_el[c]++;
                    if (m_el[c] == 256) begin m_res[c] = 255; ov = 1'b1; end
                end
                if (fault_clr) m_flt[c] = fault_en[c] && (m_el[c] > 255);
                else           m_flt[c] = m_flt[c] || (fault_en[c] && ov);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && running) begin
            for (int c = 0; c < NCH; c++) begin
                check($sformatf("R3 R4 R9 result ch%0d", c), int'(result_o[c*8 +: 8]), m_res[c]);
                check($sformatf("R6 R7 R8 fault ch%0d", c), int'(fault_o[c]), int'(m_flt[c]));
            end
        end
    end

    task automatic tach_gen(input int c);
        forever begin
            if (period[c] == 0) @(negedge clk);
            else begin
                int p;
                p = period[c];
                tach_in[c] = 1'b1;
                repeat (p / 2) @(negedge clk);
                tach_in[c] = 1'b0;
                repeat (p - p / 2) @(negedge clk);
            end
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) base_en = ~base_en;
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        period[0] = 0; period[1] = 0;
        fork tach_gen(0); tach_gen(1); join_none
        repeat (4) @(negedge clk);
        // R5: reset values
        check("R5 result ch0", int'(result_o[7:0]), 255);
        check("R5 result ch1", int'(result_o[15:8]), 255);
        check("R5 fault", int'(fault_o), 0);
        rst_n = 1'b1;
        running = 1'b1;
        // R1 R2 R3: each divide setting with distinct periods
        period[0] = 100; period[1] = 300;
        repeat (3000) @(negedge clk);
        check("R1 R3 div2 ch0", int'(result_o[7:0]), 25);
        check("R1 R3 div2 ch1", int'(result_o[15:8]), 75);
        div_sel = 2'b10; period[0] = 160; period[1] = 480;
        repeat (4000) @(negedge clk);
        check("R1 R3 div4 ch0", int'(result_o[7:0]), 20);
        check("R1 R3 div4 ch1", int'(result_o[15:8]), 60);
        div_sel = 2'b01; period[1] = 800;
        repeat (4000) @(negedge clk);
        check("R1 R2 div8 ch1", int'(result_o[15:8]), 50);
        div_sel = 2'b00;
        repeat (4000) @(negedge clk);
        check("R1 R2 div16 ch1", int'(result_o[15:8]), 25);
        // R4 R6 R8: stall both fans, fault enabled on ch1 only
        div_sel = 2'b11; fault_en = 2'b10;
        period[0] = 0; period[1] = 0;
        repeat (2000) @(negedge clk);
        check("R4 stall ch0", int'(result_o[7:0]), 255);
        check("R4 stall ch1", int'(result_o[15:8]), 255);
        check("R6 fault ch1", int'(fault_o[1]), 1);
        check("R8 no fault ch0", int'(fault_o[0]), 0);
        // R7: clear while still overflowed re-raises; enable ch0 first
        fault_en = 2'b11;
        fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
        @(negedge clk);
        check("R7 rearm ch1", int'(fault_o[1]), 1);
        check("R7 rearm ch0", int'(fault_o[0]), 1);
        // R4 R7: restart ch1, stall-ending edge then fresh count
        period[1] = 200;
        repeat (1000) @(negedge clk);
        check("R4 recover ch1", int'(result_o[15:8]), 50);
        check("R7 held ch1", int'(fault_o[1]), 1);
        fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
        @(negedge clk);
        check("R7 cleared ch1", int'(fault_o[1]), 0);
        check("R7 R9 ch0 still stalled", int'(fault_o[0]), 1);
        repeat (200) @(negedge clk);
        running = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule